// File: doc/BRIEF.md
# Asynchronous Static RAM Bus Controller

This block sits between a synchronous host port and an asynchronous 128K x 8 static RAM. The host hands over one request at a time (read or write, one byte, 17-bit address) with a valid/ready handshake. The controller then plays out the pin-level cycle on the RAM: two chip selects of opposite polarity, an active-low write enable, an active-low output enable, and a data bus split into an output word, an input word and a driver enable for the pad tristate.

The strobe widths are counted in system clocks. The minimum device times are given in nanoseconds together with the clock period. Each count is the ceiling of time over period, with a floor of one clock. This lets one parameter set cover each speed grade. A write is framed by the overlap of the two selects and write enable. A read holds output enable low for the access count and captures the RAM data on the last clock of that count. The captured byte is returned with a one-cycle valid pulse.

Top module: `sram_ctl`

## Requirements
- R1: After reset, `mem_sel_n` is 1, `mem_sel` is 0, `mem_we_n` and `mem_oe_n` are 1, `mem_dq_oe` is 0, `host_ready` is 1 and `rsp_valid` is 0.
- R2: The RAM is selected (`mem_sel_n`=0 and `mem_sel`=1) only during an access. The two selects are always complements of each other.
- R3: In a write, `mem_we_n` stays low for exactly WP clocks. WP is the largest of ceil(T_WP/CLK), ceil(T_DW/CLK) and ceil(T_AW/CLK)-1, and at least 1. This is 11 for the defaults. The data driver is on in exactly those clocks, and the address and write data stay stable through them.
- R4: A write keeps the RAM selected for exactly 1 + WP + WR clocks. WR is max(1, ceil(T_WC/CLK)-1-WP). This is 14 clocks for the defaults.
- R5: In a read, `mem_oe_n` is low and the RAM is selected for exactly RD clocks. RD is the largest of the ceilings of T_AA, T_OE and T_RC over CLK. This is 14 for the defaults. Write enable stays high and the driver stays off throughout.
- R6: Read data sampled on the last clock of the read access appears on `rsp_rdata` with `rsp_valid` high for exactly one clock, in the clock after that access.
- R7: `host_ready` is high only while idle. A request is taken in a clock where `host_valid` and `host_ready` are both high, and `host_ready` is low in the clock that follows.
- R8: A write accepted right after a read completes gets one extra turnaround clock, with the RAM deselected, output enable high and the driver off. As a result, write enable falls no sooner than the fourth clock after output enable rises.
- R9: The data driver is never on while output enable is low. Write enable and output enable are never low together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| host_valid | input | 1 | Request present |
| host_ready | output | 1 | Controller idle, request taken this clock |
| host_write | input | 1 | 1 = write, 0 = read |
| host_addr | input | 17 | Byte address |
| host_wdata | input | 8 | Write byte |
| rsp_valid | output | 1 | One-clock pulse with read data |
| rsp_rdata | output | 8 | Read byte |
| mem_addr | output | 17 | RAM address pins |
| mem_sel_n | output | 1 | Active-low chip select |
| mem_sel | output | 1 | Active-high chip select |
| mem_we_n | output | 1 | Active-low write enable |
| mem_oe_n | output | 1 | Active-low output enable |
| mem_dq_out | output | 8 | Byte driven onto the RAM data pins |
| mem_dq_oe | output | 1 | Pad driver enable for the data pins |
| mem_dq_in | input | 8 | Byte read from the RAM data pins |

## Verification
Two events can land in the same clock: the one-clock read response and the acceptance of the next request, since the controller is idle in the response clock. The bench provokes this by queuing a write straight behind a read, and a read straight behind a read. A scoreboard checks the returned byte. A pin-level RAM model measures the turnaround gap between output enable rising and write enable falling, so a missing turnaround clock or a response lost to the new request is reported.

// File: rtl/sram_ctl.sv
module sram_ctl #(
  parameter int AW     = 17,
  parameter int DW     = 8,
  parameter int CLK_NS = 4,
  parameter int T_WP   = 40,
  parameter int T_DW   = 25,
  parameter int T_AW   = 45,
  parameter int T_WC   = 55,
  parameter int T_AA   = 55,
  parameter int T_OE   = 25,
  parameter int T_RC   = 55
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          host_valid,
  output logic          host_ready,
  input  logic          host_write,
  input  logic [AW-1:0] host_addr,
  input  logic [DW-1:0] host_wdata,
  output logic          rsp_valid,
  output logic [DW-1:0] rsp_rdata,
  output logic [AW-1:0] mem_addr,
  output logic          mem_sel_n,
  output logic          mem_sel,
  output logic          mem_we_n,
  output logic          mem_oe_n,
  output logic [DW-1:0] mem_dq_out,
  output logic          mem_dq_oe,
  input  logic [DW-1:0] mem_dq_in
);

  function automatic int clks(int t);
    int c;
    c = (t + CLK_NS - 1) / CLK_NS;
    return (c < 1) ? 1 : c;
  endfunction

  function automatic int max2(int a, int b);
    return (a > b) ? a : b;
  endfunction

  localparam int WP_N = max2(1, max2(clks(T_WP), max2(clks(T_DW), clks(T_AW) - 1)));
  localparam int WR_N = max2(1, clks(T_WC) - 1 - WP_N);
  localparam int RD_N = max2(clks(T_AA), max2(clks(T_OE), clks(T_RC)));
  localparam int CW   = $clog2(max2(WP_N, max2(WR_N, RD_N)) + 1);

  typedef enum logic [2:0] {
    S_IDLE, S_TURN, S_WSET, S_WPUL, S_WREC, S_RACC
  } state_t;

  state_t          state;
  logic [CW-1:0]   cnt;
  logic            last_rd;
  logic [DW-1:0]   wdata_q;

  wire active = (state == S_WSET) || (state == S_WPUL) ||
                (state == S_WREC) || (state == S_RACC);

  assign host_ready = (state == S_IDLE);
  assign mem_sel_n  = !active;
  assign mem_sel    = active;
  assign mem_we_n   = (state != S_WPUL);
  assign mem_oe_n   = (state != S_RACC);
  assign mem_dq_oe  = (state == S_WPUL);
  assign mem_dq_out = wdata_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= S_IDLE;
      cnt       <= '0;
      last_rd   <= 1'b0;
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
      mem_addr  <= '0;
      wdata_q   <= '0;
    end else begin
      rsp_valid <= 1'b0;
      case (state)
        S_IDLE: if (host_valid) begin
          mem_addr <= host_addr;
          wdata_q  <= host_wdata;
          if (host_write) begin
            state <= last_rd ? S_TURN : S_WSET;
          end else begin
            state <= S_RACC;
            cnt   <= CW'(RD_N - 1);
          end
        end
        S_TURN: begin
          state   <= S_WSET;
          last_rd <= 1'b0;
        end
        S_WSET: begin
          state   <= S_WPUL;
          cnt     <= CW'(WP_N - 1);
          last_rd <= 1'b0;
        end
        S_WPUL: if (cnt == '0) begin
          state <= S_WREC;
          cnt   <= CW'(WR_N - 1);
        end else begin
          cnt <= cnt - 1'b1;
        end
        S_WREC: if (cnt == '0) state <= S_IDLE;
                else cnt <= cnt - 1'b1;
        S_RACC: if (cnt == '0) begin
          rsp_rdata <= mem_dq_in;
          rsp_valid <= 1'b1;
          last_rd   <= 1'b1;
          state     <= S_IDLE;
        end else begin
          cnt <= cnt - 1'b1;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

endmodule

module sram_ctl_chk #(
  parameter int AW = 17
) (
  input logic          clk,
  input logic          rst,
  input logic          host_valid,
  input logic          host_ready,
  input logic          rsp_valid,
  input logic [AW-1:0] mem_addr,
  input logic          mem_sel_n,
  input logic          mem_sel,
  input logic          mem_we_n,
  input logic          mem_oe_n,
  input logic          mem_dq_oe
);

  // R1
  reset_idle_chk: assert property (@(posedge clk)
    rst |=> (mem_sel_n && !mem_sel && mem_we_n && mem_oe_n && !mem_dq_oe && !rsp_valid));

  // R2
  sel_pair_chk: assert property (@(posedge clk) disable iff (rst)
    mem_sel_n == !mem_sel);

  // R2
  strobe_needs_sel_chk: assert property (@(posedge clk) disable iff (rst)
    (!mem_we_n || !mem_oe_n) |-> !mem_sel_n);

  // R3
  drive_with_we_chk: assert property (@(posedge clk) disable iff (rst)
    mem_dq_oe == !mem_we_n);

  // R3
  addr_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!mem_we_n && $past(!mem_we_n)) |-> $stable(mem_addr));

  // R6
  rsp_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |=> !rsp_valid);

  // R7
  accept_busy_chk: assert property (@(posedge clk) disable iff (rst)
    (host_valid && host_ready) |=> !host_ready);

  // R9
  no_contention_chk: assert property (@(posedge clk) disable iff (rst)
    !(mem_dq_oe && !mem_oe_n) && !(!mem_we_n && !mem_oe_n));

endmodule

bind sram_ctl sram_ctl_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst(rst), .host_valid(host_valid), .host_ready(host_ready),
  .rsp_valid(rsp_valid), .mem_addr(mem_addr), .mem_sel_n(mem_sel_n),
  .mem_sel(mem_sel), .mem_we_n(mem_we_n), .mem_oe_n(mem_oe_n),
  .mem_dq_oe(mem_dq_oe)
);

// File: tb/sram_ctl_bench.sv
module sram_ctl_bench;
  localparam int AW = 17;
  localparam int DW = 8;
  localparam int WP_E  = 11;
  localparam int SEL_E = 14;
  localparam int RD_E  = 14;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic host_valid = 1'b0, host_write = 1'b0;
  logic [AW-1:0] host_addr = '0;
  logic [DW-1:0] host_wdata = '0;
  logic host_ready, rsp_valid;
  logic [DW-1:0] rsp_rdata;
  logic [AW-1:0] mem_addr;
  logic mem_sel_n, mem_sel, mem_we_n, mem_oe_n, mem_dq_oe;
  logic [DW-1:0] mem_dq_out, mem_dq_in;

  int total = 0, bad = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  sram_ctl u_sram_ctl (
    .clk(clk), .rst(rst), .host_valid(host_valid), .host_ready(host_ready),
    .host_write(host_write), .host_addr(host_addr), .host_wdata(host_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .mem_addr(mem_addr),
    .mem_sel_n(mem_sel_n), .mem_sel(mem_sel), .mem_we_n(mem_we_n),
    .mem_oe_n(mem_oe_n), .mem_dq_out(mem_dq_out), .mem_dq_oe(mem_dq_oe),
    .mem_dq_in(mem_dq_in)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [DW-1:0] pattern(input logic [AW-1:0] a);
    return a[7:0] ^ a[16:9];
  endfunction

  // RAM pin model
  logic [DW-1:0] ram [int];
  logic [DW-1:0] ram_dq = 'x;
  int  rd_age = 0, wp_len = 0, sel_len = 0, oe_len = 0, oe_gap = 100;
  bit  was_wr = 0, was_sel = 0, dstable = 1, after_rd = 0;
  logic [DW-1:0] wr_byte;
  logic [AW-1:0] wr_at;

  assign mem_dq_in = ram_dq;

  function automatic logic [DW-1:0] ram_rd(input logic [AW-1:0] a);
    return ram.exists(int'(a)) ? ram[int'(a)] : pattern(a);
  endfunction

  always @(negedge clk) if (!rst) begin
    automatic bit sel = !mem_sel_n && mem_sel;
    automatic bit wr  = sel && !mem_we_n;
    if (wr) begin
      if (!was_wr) begin
        if (after_rd) check(oe_gap >= 3, "R8 turnaround gap", oe_gap, 3);
        after_rd = 0;
        wr_byte = mem_dq_out; wr_at = mem_addr; dstable = 1; wp_len = 0;
      end
      if (!mem_dq_oe || mem_dq_out !== wr_byte || mem_addr !== wr_at) dstable = 0;
      wp_len++;
    end else if (was_wr) begin
      ram[int'(wr_at)] = wr_byte;
      check(wp_len == WP_E, "R3 write pulse clocks", wp_len, WP_E);
      check(dstable, "R3 data/addr/driver held in pulse", dstable, 1);
    end
    was_wr = wr;
    if (sel && !mem_oe_n && mem_we_n) begin
      rd_age++; oe_len++;
      if (mem_dq_oe) check(0, "R5 driver off in read", 1, 0);
    end else rd_age = 0;
    ram_dq = (rd_age >= RD_E) ? ram_rd(mem_addr) : 'x;
    if (!mem_oe_n) begin oe_gap = 0; after_rd = 1; end
    else oe_gap++;
    if (sel) sel_len++;
    else if (was_sel) begin
      if (oe_len > 0) begin
        check(oe_len == RD_E, "R5 output enable clocks", oe_len, RD_E);
        check(sel_len == RD_E, "R5 read select clocks", sel_len, RD_E);
      end else
        check(sel_len == SEL_E, "R4 write select clocks", sel_len, SEL_E);
      check(mem_sel_n && !mem_sel, "R2 deselected between accesses", {mem_sel_n, mem_sel}, 2);
      sel_len = 0; oe_len = 0;
    end
    was_sel = sel;
  end

  // scoreboard
  logic [DW-1:0] expq[$];
  logic [DW-1:0] gold [int];
  bit rsp_prev = 0;

  always @(negedge clk) if (!rst) begin
    if (rsp_prev) check(!rsp_valid, "R6 response one clock", rsp_valid, 0);
    if (rsp_valid) begin
      if (expq.size() == 0) check(0, "R6 unexpected response", rsp_rdata, 0);
      else begin
        automatic logic [DW-1:0] e = expq.pop_front();
        check(rsp_rdata === e, "R6 read data", rsp_rdata, e);
      end
    end
    rsp_prev = rsp_valid;
  end

  task automatic issue(input bit w, input logic [AW-1:0] a, input logic [DW-1:0] d);
    host_valid = 1; host_write = w; host_addr = a; host_wdata = d;
    if (w) gold[int'(a)] = d;
    else expq.push_back(gold.exists(int'(a)) ? gold[int'(a)] : pattern(a));
    while (!host_ready) @(negedge clk);
    @(negedge clk);
    host_valid = 0;
    check(!host_ready, "R7 busy after accept", host_ready, 0);
  endtask

  task automatic drain();
    while (expq.size() != 0 || !host_ready) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1
    check(mem_sel_n && !mem_sel && mem_we_n && mem_oe_n && !mem_dq_oe,
          "R1 pins idle in reset", {mem_sel_n, mem_sel, mem_we_n, mem_oe_n, mem_dq_oe}, 5'b10110);
    check(host_ready && !rsp_valid, "R1 host side in reset", {host_ready, rsp_valid}, 2);
    rst = 0;
    @(negedge clk);
    issue(1, 17'h00010, 8'h5A);
    issue(0, 17'h00010, 8'h00);
    issue(0, 17'h0ABCD, 8'h00);
    issue(1, 17'h1FFFF, 8'hFF);
    issue(1, 17'h00000, 8'h00);
    issue(0, 17'h1FFFF, 8'h00);
    issue(1, 17'h00001, 8'hA5);   // R8 write right after read
    issue(0, 17'h00000, 8'h00);
    issue(0, 17'h00001, 8'h00);
    issue(1, 17'h12345, 8'h3C);   // R8 again
    issue(1, 17'h12346, 8'hC3);
    issue(0, 17'h12345, 8'h00);
    issue(0, 17'h12346, 8'h00);
    drain();
    check(host_ready && mem_sel_n && mem_we_n && mem_oe_n, "R7 idle after run",
          {host_ready, mem_sel_n, mem_we_n, mem_oe_n}, 4'hF);
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule